// File: doc/BRIEF.md
# Duplicated Event Counter Monitor

This block watches the access traffic of a protected register file and keeps statistics on it: one read counter per register, plus global totals for reads, writes, reads whose data was repaired, and reads whose data was reported unusable. All counters saturate at all ones instead of wrapping. The counter set is built twice from the same increment signals. A compare output rises whenever the two copies disagree, so a flipped counter bit shows up at once.

Software reads and clears the counters through a small memory-mapped slave port. The port has a strobe, a write-enable and a word address. A bus state machine has two states. `BUS_IDLE` samples a strobe. It moves to `BUS_RESP`, which raises the acknowledge for exactly one cycle and then returns to `BUS_IDLE`. The transition out of `BUS_IDLE` captures read data, or clears the addressed counter on a write. Addresses that hold no counter are acknowledged like any other access, return zero and change nothing.

Top module: `evmon_top`

## Requirements
- R1: After reset every counter in both copies reads as zero, and `mismatch` is low.
- R2: A cycle with `ev_read` high adds one to the per-register counter selected by `ev_idx` and one to the total-reads counter.
- R3: A cycle with `ev_write` high adds one to the total-writes counter. It may coincide with a read event, and then both are counted.
- R4: On a read event, `ev_status` 1 (repaired) adds one to the repaired counter and `ev_status` 2 (unusable) adds one to the unusable counter. Status 0 (clean) and 3 touch neither counter.
- R5: A counter at all ones stays at all ones when further events arrive.
- R6: Bit `AW-1` of `bus_addr` selects the copy (0 = first, 1 = second). The low bits select the counter. Indices 0 to NREG-1 are the per-register counters. NREG is total reads, NREG+1 is total writes, NREG+2 is repaired and NREG+3 is unusable. Read data is the counter zero-extended to 32 bits.
- R7: A bus write to any mapped address clears that counter in both copies. If an increment arrives in the same cycle, the clear wins and the counter ends at zero.
- R8: An access to an unmapped index is acknowledged, reads as zero and leaves every counter unchanged.
- R9: A strobe seen in `BUS_IDLE` gives `bus_ack` high in the next cycle, for exactly one cycle.
- R10: `mismatch` is high exactly when some counter differs between the two copies. It stays low in fault-free operation.
- R11: The same counter read from the first and the second copy returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_read | input | 1 | Register file read event this cycle |
| ev_write | input | 1 | Register file write event this cycle |
| ev_idx | input | $clog2(NREG) | Register index of the read event |
| ev_status | input | 2 | Read status: 0 clean, 1 repaired, 2 unusable |
| bus_stb | input | 1 | Bus access strobe, held until acknowledged |
| bus_we | input | 1 | Bus access is a write (clear) |
| bus_addr | input | AW | Word address: copy bit plus counter index |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Single-cycle access acknowledge |
| mismatch | output | 1 | The two counter copies disagree |

## Verification
Two functions can fall in the same cycle: a bus write that clears a counter, and an event that increments the same counter. The bench provokes this by raising the strobe for a clear of one per-register counter in the same cycle as a read event on that register. It then expects that counter to read zero in both copies. The total-reads counter, which is not cleared, must still show the increment. Both copies are read back afterwards, so a clear applied to only one copy is caught in the per-copy values and in `mismatch`.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    // read status codes reported by the register file
    localparam logic [1:0] RS_CLEAN    = 2'd0;
    localparam logic [1:0] RS_REPAIRED = 2'd1;
    localparam logic [1:0] RS_UNUSABLE = 2'd2;

    // global counters, placed after the per-register block
    localparam int G_READS    = 0;
    localparam int G_WRITES   = 1;
    localparam int G_REPAIRED = 2;
    localparam int G_UNUSABLE = 3;
    localparam int N_GLOBAL   = 4;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/evmon_satcnt.sv
module evmon_satcnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank #(
    parameter int CW   = 32,
    parameter int NCNT = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCNT-1:0]    inc_vec,
    input  logic [NCNT-1:0]    clr_vec,
    output logic [NCNT*CW-1:0] cnt_flat
);
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        evmon_satcnt #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_vec[i]),
            .inc   (inc_vec[i]),
            .cnt   (cnt_flat[i*CW +: CW])
        );
    end
endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
#(
    parameter int NREG = 32,
    parameter int CW   = 32,
    parameter int AW   = 7,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_read,
    input  logic          ev_write,
    input  logic [IW-1:0] ev_idx,
    input  logic [1:0]    ev_status,
    input  logic          bus_stb,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_rdata,
    output logic          bus_ack,
    output logic          mismatch
);
    localparam int NCNT = NREG + N_GLOBAL;
    localparam int XW   = AW - 1;
    localparam logic [XW-1:0] NCNT_X = XW'(NCNT);

    bus_state_e state_q, state_d;

    logic [NCNT-1:0]    inc_vec;
    logic [NCNT-1:0]    clr_vec;
    logic [NCNT*CW-1:0] cnt_a;
    logic [NCNT*CW-1:0] cnt_b;
    logic [XW-1:0]      sel_idx;
    logic               sel_copy;
    logic               sel_mapped;
    logic               take;
    logic [CW-1:0]      sel_val;

    // taps for the bound checker
    logic [CW-1:0] chk_tot_rd;
    logic          chk_tot_rd_clr;

    // ---------------- event decode ----------------
    for (genvar r = 0; r < NREG; r++) begin : g_reg_inc
        assign inc_vec[r] = ev_read && (ev_idx == IW'(r));
    end
    assign inc_vec[NREG+G_READS]    = ev_read;
    assign inc_vec[NREG+G_WRITES]   = ev_write;
    assign inc_vec[NREG+G_REPAIRED] = ev_read && (ev_status == RS_REPAIRED);
    assign inc_vec[NREG+G_UNUSABLE] = ev_read && (ev_status == RS_UNUSABLE);

    // ---------------- address decode ----------------
    assign sel_copy   = bus_addr[AW-1];
    assign sel_idx    = bus_addr[XW-1:0];
    assign sel_mapped = (sel_idx < NCNT_X);
    assign take       = (state_q == BUS_IDLE) && bus_stb;

    for (genvar c = 0; c < NCNT; c++) begin : g_clr
        assign clr_vec[c] = take && bus_we && sel_mapped && (sel_idx == XW'(c));
    end

    // ---------------- two identical banks ----------------
    evmon_bank #(.CW(CW), .NCNT(NCNT)) u_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_vec  (inc_vec),
        .clr_vec  (clr_vec),
        .cnt_flat (cnt_a)
    );

    evmon_bank #(.CW(CW), .NCNT(NCNT)) u_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_vec  (inc_vec),
        .clr_vec  (clr_vec),
        .cnt_flat (cnt_b)
    );

    always_comb begin
        mismatch = (cnt_a != cnt_b);
    end

    // ---------------- read mux ----------------
    always_comb begin
        sel_val = '0;
        if (sel_mapped) begin
            sel_val = sel_copy ? cnt_b[int'(sel_idx)*CW +: CW]
                               : cnt_a[int'(sel_idx)*CW +: CW];
        end
    end

    // ---------------- bus state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_stb) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_ack = (state_q == BUS_RESP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (take) begin
            bus_rdata         <= '0;
            bus_rdata[CW-1:0] <= bus_we ? '0 : sel_val;
        end
    end

    assign chk_tot_rd     = cnt_a[NREG*CW +: CW];
    assign chk_tot_rd_clr = clr_vec[NREG+G_READS];
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_stb,
    input logic          bus_ack,
    input logic          mismatch,
    input logic          ev_read,
    input logic [CW-1:0] tot_rd,
    input logic          tot_rd_clr
);
    // R9
    ack_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_ack) |=> bus_ack);

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R2
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_read && !tot_rd_clr && (tot_rd != '1)) |=> (tot_rd == CW'($past(tot_rd) + 1'b1)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tot_rd == '1) && !tot_rd_clr) |=> (tot_rd == '1));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tot_rd_clr |=> (tot_rd == '0));

    // R10
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mismatch);
endmodule

bind evmon_top evmon_chk #(.CW(CW)) u_evmon_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_stb    (bus_stb),
    .bus_ack    (bus_ack),
    .mismatch   (mismatch),
    .ev_read    (ev_read),
    .tot_rd     (chk_tot_rd),
    .tot_rd_clr (chk_tot_rd_clr)
);

// File: tb/evmon_top_test.sv
module evmon_top_test;
    localparam int NREG = 4;
    localparam int CW   = 4;
    localparam int AW   = 7;
    localparam int IW   = 2;
    localparam int NCNT = NREG + 4;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_read = 1'b0;
    logic          ev_write = 1'b0;
    logic [IW-1:0] ev_idx = '0;
    logic [1:0]    ev_status = '0;
    logic          bus_stb = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ack;
    logic          mismatch;

    int checks = 0;
    int errors = 0;
    int expv [NCNT];

    evmon_top #(.NREG(NREG), .CW(CW), .AW(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_read   (ev_read),
        .ev_write  (ev_write),
        .ev_idx    (ev_idx),
        .ev_status (ev_status),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .mismatch  (mismatch)
    );

    always #2 clk = ~clk;

    task automatic check(input int actual, input int expected, input string req);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int bump(input int v);
        return (v == MAXV) ? v : v + 1;
    endfunction

    task automatic model_event(input logic rd, input logic wr, input int idx, input int st);
        if (rd) begin
            expv[idx]    = bump(expv[idx]);
            expv[NREG]   = bump(expv[NREG]);
            if (st == 1) expv[NREG+2] = bump(expv[NREG+2]);
            if (st == 2) expv[NREG+3] = bump(expv[NREG+3]);
        end
        if (wr) expv[NREG+1] = bump(expv[NREG+1]);
    endtask

    task automatic ev(input logic rd, input logic wr, input int idx, input int st);
        @(negedge clk);
        ev_read   = rd;
        ev_write  = wr;
        ev_idx    = IW'(idx);
        ev_status = 2'(st);
        @(negedge clk);
        ev_read  = 1'b0;
        ev_write = 1'b0;
        model_event(rd, wr, idx, st);
    endtask

    task automatic bus(input logic we, input int addr, output int rdata, input string req);
        @(negedge clk);
        bus_stb  = 1'b1;
        bus_we   = we;
        bus_addr = AW'(addr);
        @(negedge clk);
        check(int'(bus_ack), 1, {req, " R9 ack"});
        rdata   = int'(bus_rdata);
        bus_stb = 1'b0;
        bus_we  = 1'b0;
        @(negedge clk);
        check(int'(bus_ack), 0, "R9 single ack");
        if (we && ((addr % 64) < NCNT)) expv[addr % 64] = 0;
    endtask

    task automatic read_all(input string req);
        int v;
        for (int c = 0; c < NCNT; c++) begin
            bus(1'b0, c, v, req);
            check(v, expv[c], {req, " copy1 R6"});
            bus(1'b0, 64 + c, v, req);
            check(v, expv[c], {req, " copy2 R11"});
        end
        check(int'(mismatch), 0, "R10 mismatch");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        for (int c = 0; c < NCNT; c++) expv[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(int'(mismatch), 0, "R1 mismatch after reset");
        read_all("R1 reset");

        // R2 R3 R4 sweep over registers, statuses and read/write mix
        for (int r = 0; r < NREG; r++) begin
            for (int k = 0; k <= r + 1; k++) begin
                ev(1'b1, (k % 2) == 1, r, k % 4);
            end
        end
        ev(1'b0, 1'b1, 0, 1);   // write only, status ignored (R4)
        ev(1'b0, 1'b0, 3, 2);   // no event, status ignored (R4)
        read_all("R2 R3 R4 sweep");

        // R5 saturation
        for (int k = 0; k < 20; k++) ev(1'b1, 1'b1, 3, 1);
        check(expv[3], MAXV, "R5 model");
        read_all("R5 saturate");

        // R7 clear through either copy's address
        bus(1'b1, 64 + 3, v, "R7 clear per-reg");
        bus(1'b1, NREG + 2, v, "R7 clear repaired");
        read_all("R7 cleared");

        // R8 unmapped accesses
        bus(1'b1, 20, v, "R8 unmapped write");
        bus(1'b1, 64 + 40, v, "R8 unmapped write copy2");
        bus(1'b0, 20, v, "R8 unmapped read");
        check(v, 0, "R8 unmapped read data");
        bus(1'b0, 127, v, "R8 unmapped read top");
        check(v, 0, "R8 unmapped read data top");
        read_all("R8 unchanged");

        // R7 clear coinciding with an increment of the same counter
        @(negedge clk);
        bus_stb   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = AW'(2);
        ev_read   = 1'b1;
        ev_idx    = IW'(2);
        ev_status = 2'(0);
        @(negedge clk);
        check(int'(bus_ack), 1, "R9 ack coincident");
        ev_read = 1'b0;
        bus_stb = 1'b0;
        bus_we  = 1'b0;
        model_event(1'b1, 1'b0, 2, 0);
        expv[2] = 0;
        read_all("R7 clear wins");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule